// File: doc/BRIEF.md
# Double-Buffered VGA Text Controller

This block drives a 640x480 display from a text grid of 80 columns by 30 rows. Each character cell is 8 pixels wide and 16 lines tall. It produces active-low horizontal and vertical sync and 2-bit red, green and blue levels, all from one 25 MHz pixel clock. A line is 800 clocks long and a frame is 525 lines. A host writes character bytes, foreground bytes, glyph rows, a shared background colour and a control byte through one byte-wide write port on the same clock.

The cell store holds two pages. In the default buffered mode, the scanner reads one page while the host fills the other. A swap request is held until the first blanking line after the visible area and applied there, so a frame always comes from a single page. A control bit switches to unbuffered mode. In that mode both pages form one linear store, the first half is what is scanned, and host writes show up on the next frame. The glyph store is written by the host, which loads the 256-character code page 437 shapes into it at start-up.

Top module: `vga_text_dbuf`

## Requirements
- R1: The hsync_n output is low for exactly H_SYNC clocks in every line of H_TOTAL clocks. The low pulse starts H_VIS+H_FP clocks after the first pixel of the line. The vsync_n output is low for V_SYNC whole lines, starting V_VIS+V_FP lines after the first visible line. Both syncs read high while reset is held.
- R2: The colour outputs are all zero outside the visible area, during either sync pulse and while reset is held.
- R3: For a visible pixel, the glyph row bit 7-(x mod 8) selects the colour. A set bit shows the cell's 6-bit foreground and a clear bit shows the 6-bit background. Colour bits [5:4] go to red, [3:2] to green and [1:0] to blue.
- R4: Pixel (x, y) belongs to cell (y/16)*COLS + x/8. In the cell window (address bit 14 clear), byte address 2*i holds the character code of cell i and byte address 2*i+1 holds its foreground in bits [5:0].
- R5: Glyph row r of character c is written at address 0x4000 + c*16 + r. The pixel uses row y mod 16 of the cell's character.
- R6: In buffered mode, cell writes land in the page that is not being scanned and do not change the picture.
- R7: Writing 0x7FFF with bit 0 set and bit 1 clear requests a swap. The scanned page changes once per request, only at the first clock of line V_VIS. A request made during the visible area leaves the current frame unchanged. With no request, the page never changes.
- R8: Writing 0x7FFF with bit 1 set selects unbuffered mode. In this mode, byte addresses 0 to 4*CELLS-1 map linearly onto both pages, only the first page is scanned, and swap requests are dropped. Writing 0x7FFE sets the background from bits [5:0].
- R9: Writes to cells beyond the writable range, or to any address outside the cell, glyph and two control locations, change nothing that is displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one write per clock |
| host_addr | input | 15 | Host byte address |
| host_data | input | 8 | Host write data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
A wrong raster counter moves a sync edge. Every later position in the line or frame then compares wrong from the first misplaced edge. A wrong page or pending flag shows a whole frame drawn from the wrong page's colours, within one frame of the request. A misaligned pipeline stage moves every glyph by a pixel, or separates colour from blanking, and this shows on the first visible line. The bench lines up on the vsync fall and compares every position of the frame.

// File: rtl/vga_text_dbuf.sv
module vga_text_dbuf #(
  parameter int COLS   = 80,
  parameter int ROWS   = 30,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [14:0] host_addr,
  input  logic [7:0]  host_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [1:0]  red,
  output logic [1:0]  green,
  output logic [1:0]  blue
);
  localparam int CELLS   = COLS * ROWS;
  localparam int H_VIS   = COLS * 8;
  localparam int V_VIS   = ROWS * 16;
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int CW      = $clog2(2 * CELLS);

  logic [13:0] cell_mem [2*CELLS];
  logic [7:0]  font_mem [4096];

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic          page, pend, unbuf;
  logic [5:0]    bg;

  wire line_end = (hc == HW'(H_TOTAL - 1));
  wire apply    = pend && line_end && (vc == VW'(V_VIS - 1));
  wire vis      = (32'(hc) < H_VIS) && (32'(vc) < V_VIS);
  wire hs       = !((32'(hc) >= H_VIS + H_FP) && (32'(hc) < H_VIS + H_FP + H_SYNC));
  wire vs       = !((32'(vc) >= V_VIS + V_FP) && (32'(vc) < V_VIS + V_FP + V_SYNC));

  wire is_cell = !host_addr[14];
  wire is_font = (host_addr[14:12] == 3'b100);
  wire is_ctrl = (host_addr == 15'h7FFF);
  wire is_bg   = (host_addr == 15'h7FFE);

  wire [31:0]   wcell  = 32'(host_addr[13:1]);
  wire          wr_ok  = unbuf ? (wcell < 2 * CELLS) : (wcell < CELLS);
  wire [CW-1:0] wr_idx = CW'(wcell + ((!unbuf && !page) ? CELLS : 0));
  wire          scan_pg = page && !unbuf;
  wire [CW-1:0] rd_idx = vis ? CW'(32'(vc >> 4) * COLS + 32'(hc >> 3) + (scan_pg ? CELLS : 0))
                             : '0;

  always_ff @(posedge clk) begin
    if (host_we && is_cell && wr_ok) begin
      if (host_addr[0]) cell_mem[wr_idx][13:8] <= host_data[5:0];
      else              cell_mem[wr_idx][7:0]  <= host_data;
    end
    if (host_we && is_font) font_mem[host_addr[11:0]] <= host_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= (vc == VW'(V_TOTAL - 1)) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page  <= 1'b0;
      pend  <= 1'b0;
      unbuf <= 1'b0;
      bg    <= '0;
    end else begin
      if (apply) page <= ~page;
      if (host_we && is_ctrl) begin
        unbuf <= host_data[1];
        pend  <= !host_data[1] && (host_data[0] || (pend && !apply));
      end else if (apply) begin
        pend <= 1'b0;
      end
      if (host_we && is_bg) bg <= host_data[5:0];
    end
  end

  logic [13:0] a_cell;
  logic [3:0]  a_line;
  logic [2:0]  a_x, b_x;
  logic [7:0]  b_bits;
  logic [5:0]  b_fg;
  logic        a_vis, a_hs, a_vs, b_vis, b_hs, b_vs;

  always_ff @(posedge clk) begin
    a_cell <= cell_mem[rd_idx];
    a_line <= vc[3:0];
    a_x    <= hc[2:0];
    b_bits <= font_mem[{a_cell[7:0], a_line}];
    b_fg   <= a_cell[13:8];
    b_x    <= a_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {a_vis, b_vis} <= 2'b00;
      {a_hs, a_vs, b_hs, b_vs, hsync_n, vsync_n} <= 6'b111111;
      {red, green, blue} <= '0;
    end else begin
      {a_vis, a_hs, a_vs} <= {vis, hs, vs};
      {b_vis, b_hs, b_vs} <= {a_vis, a_hs, a_vs};
      {hsync_n, vsync_n}  <= {b_hs, b_vs};
      {red, green, blue}  <= !b_vis ? 6'd0 : (b_bits[3'd7 - b_x] ? b_fg : bg);
    end
  end
endmodule

// File: rtl/vga_text_dbuf_chk.sv
module vga_text_dbuf_chk #(
  parameter int H_TOTAL = 800,
  parameter int H_SYNC  = 96,
  parameter int V_VIS   = 480,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [1:0]    red,
  input logic [1:0]    green,
  input logic [1:0]    blue,
  input logic          page,
  input logic          pend,
  input logic          unbuf,
  input logic [HW-1:0] hc,
  input logic [VW-1:0] vc
);
  logic        hs_prev, armed;
  logic [15:0] cnt;
  wire hs_fall = hs_prev && !hsync_n;
  wire hs_rise = !hs_prev && hsync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_prev <= 1'b1;
      armed   <= 1'b0;
      cnt     <= '0;
    end else begin
      hs_prev <= hsync_n;
      if (hs_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hs_rise) |-> (cnt == 16'(H_SYNC - 1)));

  assert_hsync_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hs_fall) |-> (cnt == 16'(H_TOTAL - 1)));

  assert_blank_hsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> ({red, green, blue} == 6'd0));

  assert_blank_vsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> ({red, green, blue} == 6'd0));

  assert_swap_at_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page) |-> (hc == '0 && vc == VW'(V_VIS) && $past(pend)));

  assert_unbuf_no_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unbuf |-> !pend);
endmodule

bind vga_text_dbuf vga_text_dbuf_chk #(
  .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .V_VIS(V_VIS), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .red(red), .green(green), .blue(blue),
  .page(page), .pend(pend), .unbuf(unbuf), .hc(hc), .vc(vc)
);

// File: tb/vga_text_dbuf_tb.sv
module vga_text_dbuf_tb;
  localparam int CLK_P = 40;
  localparam int COLS = 4, ROWS = 2;
  localparam int HFP = 2, HSY = 4, HBP = 2, VFP = 1, VSY = 2, VBP = 1;
  localparam int CELLS = COLS * ROWS;
  localparam int HV = COLS * 8, VV = ROWS * 16;
  localparam int HT = HV + HFP + HSY + HBP, VT = VV + VFP + VSY + VBP;

  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic hsync_n, vsync_n;
  logic [1:0] red, green, blue;

  vga_text_dbuf #(.COLS(COLS), .ROWS(ROWS), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
                  .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue));

  always #(CLK_P / 2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mch [2*CELLS];
  logic [5:0] mat [2*CELLS];
  logic [7:0] fnt [4096];
  logic [5:0] mbg = '0;
  bit m_unbuf = 0, m_page = 0, m_pend = 0;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic host_wr(input logic [14:0] a, input logic [7:0] d);
    int c, idx;
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
    if (a == 15'h7FFF) begin
      m_unbuf = d[1];
      m_pend  = !d[1] && (d[0] || m_pend);
    end else if (a == 15'h7FFE) begin
      mbg = d[5:0];
    end else if (a[14:12] == 3'b100) begin
      fnt[a[11:0]] = d;
    end else if (!a[14]) begin
      c = int'(a[13:1]);
      if (m_unbuf ? (c < 2 * CELLS) : (c < CELLS)) begin
        idx = m_unbuf ? c : c + (m_page ? 0 : CELLS);
        if (a[0]) mat[idx] = d[5:0];
        else      mch[idx] = d;
      end
    end
  endtask

  task automatic wait_vfall();
    logic prev;
    prev = vsync_n;
    while (1) begin
      @(negedge clk);
      if (prev && !vsync_n) break;
      prev = vsync_n;
    end
  endtask

  task automatic check_frame(input string tag, input int trig);
    int bs, bb, bp, h, v, idx, shown;
    logic [31:0] as_, es_, ab, eb, ap, ep;
    logic [5:0] act, exp;
    logic [7:0] bits;
    logic ehs, evs;
    bs = 0; bb = 0; bp = 0;
    as_ = 0; es_ = 0; ab = 0; eb = 0; ap = 0; ep = 0;
    wait_vfall();
    wait_vfall();
    if (m_pend) begin m_page = !m_page; m_pend = 0; end
    shown = m_unbuf ? 0 : int'(m_page);
    for (int k = 0; k < HT * VT; k++) begin
      if (k > 0) @(negedge clk);
      if (host_we) host_we = 1'b0;
      h = k % HT;
      v = (VV + VFP + k / HT) % VT;
      ehs = !(h >= HV + HFP && h < HV + HFP + HSY);
      evs = !(v >= VV + VFP && v < VV + VFP + VSY);
      act = {red, green, blue};
      if ({hsync_n, vsync_n} !== {ehs, evs}) begin
        if (bs == 0) begin as_ = {hsync_n, vsync_n}; es_ = {ehs, evs}; end
        bs++;
      end
      if (h < HV && v < VV) begin
        idx  = shown * CELLS + (v / 16) * COLS + h / 8;
        bits = fnt[{mch[idx], 4'(v % 16)}];
        exp  = bits[7 - h % 8] ? mat[idx] : mbg;
        if (act !== exp) begin
          if (bp == 0) begin ap = act; ep = exp; end
          bp++;
        end
      end else if (act !== 6'd0) begin
        if (bb == 0) begin ab = act; eb = 0; end
        bb++;
      end
      if (trig >= 0 && v == trig && h == 0) begin
        host_we = 1'b1; host_addr = 15'h7FFF; host_data = 8'h01;
      end
    end
    chk(bs == 0, {"R1 sync positions: ", tag}, as_, es_);
    chk(bb == 0, {"R2 blanking zero: ", tag}, ab, eb);
    chk(bp == 0, {"R3 R4 R5 visible pixels: ", tag}, ap, ep);
    if (trig >= 0) m_pend = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({red, green, blue} == 6'd0, "R2 reset colour", {red, green, blue}, 0);
    chk(hsync_n == 1'b1, "R1 reset hsync", hsync_n, 1);
    chk(vsync_n == 1'b1, "R1 reset vsync", vsync_n, 1);
    rst_n = 1'b1;

    host_wr(15'h7FFF, 8'h02);
    host_wr(15'h7FFE, 8'h2A);
    for (int i = 0; i < 2 * CELLS; i++) begin
      host_wr(15'(2 * i), (i < CELLS) ? 8'(8'h10 + i * 3) : 8'(8'hA0 ^ (i * 7)));
      host_wr(15'(2 * i + 1), (i < CELLS) ? 8'((i * 5 + 1) & 63) : 8'((i * 11 + 7) & 63));
    end
    for (int c = 0; c < 256; c++)
      for (int l = 0; l < 16; l++)
        host_wr(15'(16'h4000 + c * 16 + l), 8'(c * 37 + l * 59 + (c >> 2)));

    check_frame("R8 unbuffered shows first half", -1);
    host_wr(15'(2 * (CELLS + 1)), 8'h5C);
    host_wr(15'(2 * (CELLS + 1) + 1), 8'h33);
    check_frame("R8 second half not scanned", -1);

    host_wr(15'h7FFF, 8'h00);
    for (int i = 0; i < CELLS; i++) begin
      host_wr(15'(2 * i), 8'(8'h60 + i * 13));
      host_wr(15'(2 * i + 1), 8'((i * 9 + 3) & 63));
    end
    check_frame("R6 hidden page writes invisible", -1);

    host_wr(15'h7FFF, 8'h01);
    check_frame("R7 swap shows other page", -1);
    check_frame("R7 mid-frame request does not tear", 10);
    check_frame("R7 swap after mid-frame request", -1);
    check_frame("R7 no request keeps page", -1);

    host_wr(15'(2 * CELLS), 8'hFF);
    host_wr(15'(2 * CELLS + 1), 8'h3F);
    host_wr(15'h5000, 8'h77);
    host_wr(15'h7FFE, 8'h15);
    check_frame("R9 stray writes ignored, R8 new background", -1);
    host_wr(15'h7FFF, 8'h01);
    check_frame("R9 hidden page intact after stray writes", -1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule